// File: doc/BRIEF.md
# Frame-Clocked Seven-to-One Lane Deserializer

This block turns three serial data lanes into one wide parallel word. It is driven by a bit-rate clock that runs seven times faster than the frame rate. A fourth serial lane carries a frame-clock pattern. The block finds the frame boundaries in that pattern and collects seven bits from each data lane per frame. It hands out a 21-bit word with a one-cycle strobe each time a frame completes while it is locked to the frame pattern. It also produces a regenerated frame clock whose rising edge falls in the middle of each valid word.

The aligner searches for the frame-clock signature: four high bit-times followed by three low ones. It counts frames that repeat this signature at the expected spacing. After four consecutive good frames it declares lock. Any frame whose signature is missing at the expected position drops lock and restarts the search. An active-low shutdown input clears every register and holds all outputs low. A synchronous active-high reset does the same. In both cases the block must relock before it presents data again. The bit-rate clock and the physical line receivers are supplied from outside.

Top module: `frame_deser7`

## Requirements
- R1: Word bit 7·L+i comes from data lane L (L = 0, 1, 2) for i = 0..6. Within a frame each lane sends bit 6 first and bit 0 last.
- R2: A frame ends on the clock edge that samples its seventh bit. At that edge the last seven frame-clock samples, oldest first, read 1111000, so the frame starts where the frame-clock lane goes from low to high. When a word is loaded, `word_out` takes the new value on that same edge.
- R3: Lock (`locked` = 1) is declared on the end edge of the fourth consecutive correctly spaced good frame. That frame's word is the first one presented, and no word is presented before it.
- R4: `word_vld` is high for exactly one bit-clock cycle per completed frame, and only while `locked` is 1.
- R5: Between strobes, `word_out` holds its value.
- R6: A mismatch at the expected frame end clears lock and suppresses the strobe. Two kinds of mismatch count: a shifted frame-clock lane, caused by a slipped bit, and a wrong high/low pattern. The search then restarts, and four more good frames are needed before data is presented again.
- R7: While `shdn_n` is 0, every register is cleared on each clock edge. `word_out`, `word_vld`, `locked` and `frame_clk_out` all read 0, and lane activity has no effect on them.
- R8: After `shdn_n` returns to 1, no word is presented until four good frames have been received. The fourth frame's word is then presented.
- R9: `frame_clk_out` is 0 whenever `locked` is 0. While locked, it is low for the three cycles that start at a word load and high for the next four cycles. Sampled after each of a frame's seven bit edges, in order, it reads 0,0,1,1,1,1,0.
- R10: While `rst` is 1, all outputs read 0 after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock, seven cycles per frame |
| rst | input | 1 | Synchronous active-high reset |
| shdn_n | input | 1 | Active-low shutdown; clears all state |
| lane_in | input | 3 | Serial data lanes, one bit per clock each |
| fclk_in | input | 1 | Serial frame-clock lane (1111000 per frame) |
| word_out | output | 21 | Assembled parallel word |
| word_vld | output | 1 | One-cycle strobe for a newly loaded word |
| frame_clk_out | output | 1 | Regenerated frame clock, gated by lock |
| locked | output | 1 | Aligner has locked to the frame pattern |

## Verification
The properties assume that `rst` and `shdn_n` are sampled on the same clock as the lanes. They also assume that the word register changes only through a strobe, a shutdown or a reset. They make no assumption about the frame-clock pattern itself, so they also hold during slips and bad frames. The stimulus changes every input on the falling edge. It sends whole seven-bit frames back to back. It breaks framing only on purpose: one inserted extra bit, one frame with a wrong pattern, and a shutdown window during which frames keep arriving.

// File: rtl/deser7_pkg.sv
package deser7_pkg;

  // Frame-clock signature for one frame, oldest sample in the MSB:
  // 'high' ones followed by (bits - high) zeros.
  function automatic int unsigned frame_pattern(input int unsigned bits,
                                                input int unsigned high);
    return ((32'd1 << high) - 32'd1) << (bits - high);
  endfunction

endpackage

// File: rtl/d7_lane_shift.sv
module d7_lane_shift #(
  parameter int unsigned BITS = 7
) (
  input  logic            clk,
  input  logic            clr,
  input  logic            din,
  output logic [BITS-1:0] word_o
);
  // Earliest received bit ends up in the MSB (highest index first).
  logic [BITS-2:0] sreg_q;

  assign word_o = {sreg_q, din};

  always_ff @(posedge clk) begin
    if (clr) sreg_q <= '0;
    else     sreg_q <= word_o[BITS-2:0];
  end
endmodule

// File: rtl/d7_frame_align.sv
module d7_frame_align #(
  parameter int unsigned BITS        = 7,
  parameter int unsigned HIGH        = 4,
  parameter int unsigned LOCK_FRAMES = 4
) (
  input  logic clk,
  input  logic clr,
  input  logic fclk_in,
  output logic load_o,
  output logic locked_o,
  output logic fco_o
);
  localparam int unsigned CW = $clog2(BITS);
  localparam int unsigned HW = $clog2(LOCK_FRAMES + 1);
  localparam logic [BITS-1:0] PAT    = BITS'(deser7_pkg::frame_pattern(BITS, HIGH));
  localparam logic [CW-1:0]   LAST   = CW'(BITS - 1);
  localparam logic [CW-1:0]   FCO_ON = CW'(BITS - HIGH);
  localparam logic [HW-1:0]   HFULL  = HW'(LOCK_FRAMES);

  logic [BITS-2:0] hist_q;
  logic [CW-1:0]   cnt_q, cnt_n;
  logic [HW-1:0]   hits_q, hits_n;
  logic            locked_q, fco_q;
  logic [BITS-1:0] win;
  logic            match, tracking, at_exp, frame_end, locked_n;

  assign win      = {hist_q, fclk_in};
  assign match    = (win == PAT);
  assign tracking = (hits_q != '0);
  assign at_exp   = (cnt_q == LAST);

  always_comb begin
    hits_n    = hits_q;
    cnt_n     = at_exp ? cnt_q : cnt_q + CW'(1);
    frame_end = 1'b0;
    if (tracking) begin
      if (at_exp) begin
        if (match) begin
          hits_n    = (hits_q == HFULL) ? HFULL : hits_q + HW'(1);
          cnt_n     = '0;
          frame_end = 1'b1;
        end else begin
          hits_n = '0;
        end
      end
    end else if (match) begin
      hits_n    = HW'(1);
      cnt_n     = '0;
      frame_end = 1'b1;
    end
  end

  assign locked_n = (hits_n == HFULL);
  assign load_o   = frame_end && locked_n;
  assign locked_o = locked_q;
  assign fco_o    = fco_q;

  always_ff @(posedge clk) begin
    if (clr) begin
      hist_q   <= '0;
      cnt_q    <= '0;
      hits_q   <= '0;
      locked_q <= 1'b0;
      fco_q    <= 1'b0;
    end else begin
      hist_q   <= win[BITS-2:0];
      cnt_q    <= cnt_n;
      hits_q   <= hits_n;
      locked_q <= locked_n;
      fco_q    <= locked_n && (cnt_n >= FCO_ON);
    end
  end
endmodule

// File: rtl/d7_word_reg.sv
module d7_word_reg #(
  parameter int unsigned W = 21
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] word_o,
  output logic         vld_o
);
  always_ff @(posedge clk) begin
    if (clr) begin
      word_o <= '0;
      vld_o  <= 1'b0;
    end else begin
      vld_o <= load;
      if (load) word_o <= din;
    end
  end
endmodule

// File: rtl/frame_deser7.sv
module frame_deser7 #(
  parameter int unsigned NLANES      = 3,
  parameter int unsigned BITS        = 7,
  parameter int unsigned HIGH        = 4,
  parameter int unsigned LOCK_FRAMES = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     shdn_n,
  input  logic [NLANES-1:0]        lane_in,
  input  logic                     fclk_in,
  output logic [NLANES*BITS-1:0]   word_out,
  output logic                     word_vld,
  output logic                     frame_clk_out,
  output logic                     locked
);
  localparam int unsigned WORD_W = NLANES * BITS;

  logic              clr;
  logic              load;
  logic [WORD_W-1:0] word_next;

  assign clr = rst | ~shdn_n;

  for (genvar l = 0; l < NLANES; l++) begin : g_lane
    d7_lane_shift #(.BITS(BITS)) lane_i (
      .clk    (clk),
      .clr    (clr),
      .din    (lane_in[l]),
      .word_o (word_next[l*BITS +: BITS])
    );
  end

  d7_frame_align #(
    .BITS(BITS), .HIGH(HIGH), .LOCK_FRAMES(LOCK_FRAMES)
  ) align_i (
    .clk      (clk),
    .clr      (clr),
    .fclk_in  (fclk_in),
    .load_o   (load),
    .locked_o (locked),
    .fco_o    (frame_clk_out)
  );

  d7_word_reg #(.W(WORD_W)) out_i (
    .clk    (clk),
    .clr    (clr),
    .load   (load),
    .din    (word_next),
    .word_o (word_out),
    .vld_o  (word_vld)
  );
endmodule

// File: rtl/d7_deser_chk.sv
module d7_deser_chk #(
  parameter int unsigned W = 21
) (
  input logic         clk,
  input logic         rst,
  input logic         shdn_n,
  input logic [W-1:0] word_out,
  input logic         word_vld,
  input logic         frame_clk_out,
  input logic         locked
);
  // R4: strobe only while locked
  a_r4_vld_only_locked: assert property (@(posedge clk) disable iff (rst)
    word_vld |-> locked);

  // R4: strobe lasts a single cycle
  a_r4_vld_single: assert property (@(posedge clk) disable iff (rst)
    word_vld |=> !word_vld);

  // R3: lock appears together with the first presented word
  a_r3_lock_with_word: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> word_vld);

  // R5: word holds between strobes (outside shutdown)
  a_r5_hold: assert property (@(posedge clk) disable iff (rst || !shdn_n)
    (!word_vld && $past(shdn_n)) |-> $stable(word_out));

  // R7: shutdown clears all outputs on the next edge
  a_r7_shutdown_clears: assert property (@(posedge clk) disable iff (rst)
    !shdn_n |=> (word_out == '0 && !word_vld && !locked && !frame_clk_out));

  // R9: regenerated frame clock gated by lock
  a_r9_fco_needs_lock: assert property (@(posedge clk) disable iff (rst)
    frame_clk_out |-> locked);
endmodule

bind frame_deser7 d7_deser_chk #(.W(WORD_W)) chk_i (
  .clk           (clk),
  .rst           (rst),
  .shdn_n        (shdn_n),
  .word_out      (word_out),
  .word_vld      (word_vld),
  .frame_clk_out (frame_clk_out),
  .locked        (locked)
);

// File: tb/frame_deser7_tb_top.sv
module frame_deser7_tb_top;
  localparam int NL = 3;
  localparam int NB = 7;
  localparam int W  = NL * NB;
  localparam logic [NB-1:0] GOOD = 7'b1111000;
  localparam logic [NB-1:0] BAD  = 7'b1110000;
  localparam logic [NB-1:0] FCO_LOCKED = 7'b0011110;

  logic          clk = 1'b0;
  logic          rst, shdn_n, fclk;
  logic [NL-1:0] lanes;
  logic [W-1:0]  word;
  logic          vld, fco, lck;

  always #2 clk = ~clk;

  frame_deser7 dut_i (
    .clk(clk), .rst(rst), .shdn_n(shdn_n), .lane_in(lanes), .fclk_in(fclk),
    .word_out(word), .word_vld(vld), .frame_clk_out(fco), .locked(lck)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;
  logic [W-1:0] last_word = '0;

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drives one frame MSB-first; bench-side expectation of the mapping (R1).
  // Checks the hold behaviour (R5) at the six inner bit edges.
  task automatic send_frame(input logic [W-1:0] w, input logic [NB-1:0] pat,
                            output logic v, output logic [W-1:0] got,
                            output logic [NB-1:0] fco_seen);
    for (int b = 0; b < NB; b++) begin
      logic [NL-1:0] d;
      for (int l = 0; l < NL; l++) d[l] = w[l*NB + NB-1-b];
      fclk  = pat[NB-1-b];
      lanes = d;
      @(negedge clk);
      fco_seen[NB-1-b] = fco;
      if (b < NB-1)
        check(!vld && word == last_word, "R5 hold", {vld, word}, {1'b0, last_word});
    end
    v   = vld;
    got = word;
  endtask

  task automatic frame_expect(input logic [W-1:0] w, input logic [NB-1:0] pat,
                              input bit exp_vld, input bit exp_lock,
                              input bit chk_fco, input logic [NB-1:0] exp_fco,
                              input string req);
    logic v; logic [W-1:0] got; logic [NB-1:0] fs;
    send_frame(w, pat, v, got, fs);
    check(v == exp_vld, {req, " strobe"}, 32'(v), 32'(exp_vld));
    check(lck == exp_lock, {req, " lock"}, 32'(lck), 32'(exp_lock));
    if (exp_vld) begin
      check(got == w, {req, " word"}, 32'(got), 32'(w));
      last_word = w;
    end
    if (chk_fco) check(fs == exp_fco, "R9 frame clock", 32'(fs), 32'(exp_fco));
  endtask

  task automatic relock(input string req);
    for (int i = 0; i < 3; i++)
      frame_expect(W'($urandom), GOOD, 1'b0, 1'b0, 1'b1, 7'b0, req);
    frame_expect(W'($urandom), GOOD, 1'b1, 1'b1, 1'b1, 7'b0, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL R4 watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; shdn_n = 1'b1; fclk = 1'b0; lanes = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    check(word == '0 && !vld && !lck && !fco, "R10 reset",
          {fco, lck, vld, word}, 32'd0);
    rst = 1'b0;
    @(negedge clk); @(negedge clk);

    // R3 / R2: first three frames silent, fourth presents its word
    relock("R3");

    // R1: one-hot sweep over every word bit
    for (int i = 0; i < W; i++)
      frame_expect(W'(1) << i, GOOD, 1'b1, 1'b1, 1'b1, FCO_LOCKED, "R1");
    // R2 / R4: random words back to back
    for (int i = 0; i < 30; i++)
      frame_expect(W'($urandom), GOOD, 1'b1, 1'b1, 1'b1, FCO_LOCKED, "R2");

    // R6: slip one extra bit on all lanes
    fclk = 1'b0; lanes = NL'($urandom);
    @(negedge clk);
    check(!vld && word == last_word, "R6 slip hold", {vld, word}, {1'b0, last_word});
    frame_expect(W'($urandom), GOOD, 1'b0, 1'b0, 1'b0, 7'b0, "R6 slip");
    for (int i = 0; i < 2; i++)
      frame_expect(W'($urandom), GOOD, 1'b0, 1'b0, 1'b1, 7'b0, "R6 relock");
    frame_expect(W'($urandom), GOOD, 1'b1, 1'b1, 1'b1, 7'b0, "R6 relock");
    frame_expect(W'($urandom), GOOD, 1'b1, 1'b1, 1'b1, FCO_LOCKED, "R6 locked");

    // R6: wrong frame-clock pattern at the expected position
    frame_expect(W'($urandom), BAD, 1'b0, 1'b0, 1'b0, 7'b0, "R6 bad pattern");
    relock("R6 after bad");
    frame_expect(W'($urandom), GOOD, 1'b1, 1'b1, 1'b1, FCO_LOCKED, "R6 locked");

    // R7: shutdown clears and ignores lane activity
    shdn_n = 1'b0;
    @(negedge clk);
    check(word == '0 && !vld && !lck && !fco, "R7 shutdown",
          {fco, lck, vld, word}, 32'd0);
    last_word = '0;
    for (int i = 0; i < 5; i++)
      frame_expect(W'($urandom), GOOD, 1'b0, 1'b0, 1'b1, 7'b0, "R7 ignored");
    shdn_n = 1'b1;

    // R8: relock after shutdown release
    relock("R8");
    for (int i = 0; i < 5; i++)
      frame_expect(W'($urandom), GOOD, 1'b1, 1'b1, 1'b1, FCO_LOCKED, "R8 data");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule